// File: doc/BRIEF.md
# Intrablock Dependency Predecoder

The block looks at one fetch block of instruction slots and, for every source operand of every slot, finds the nearest earlier slot in the same block that writes the register that operand reads. The result is a small code per operand. A code of 0 means no producer inside the block. A code of k means the producer sits k slots before the consumer. Each code is as wide as the log2 of the slot count. The block therefore gives 2·N·log2(N) annotation bits per block, with two sources per slot. These bits are meant to be stored next to the instructions when a line is filled into the instruction cache, or on its first access. A later renaming stage can then route dependent operands directly and skip their associative and table lookups.

The caller supplies the register fields already decoded for each slot: a slot-valid bit, a has-destination bit, the destination register and the two source registers. The caller also supplies a start offset, which marks the first slot at which execution enters the block. A slot located before that offset is never used as a producer. A slot is also never a producer when it has no destination, when it writes the hardwired zero register (register 0), or when its valid bit is clear.

The block has no control state. The search logic is combinational and feeds one register stage. When `in_valid` is high at a clock edge, the codes are captured and `out_valid` goes high for the following cycle. When `in_valid` is low, the captured codes are held.

Top module: `intrablock_predecoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and every bit of `dep_codes` is 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge. The codes of a block presented with `in_valid`=1 appear on `dep_codes` one cycle later.
- R3: A nonzero code k for an operand of slot i means that slot i−k is a producer whose destination equals that source register. When such a producer exists among the earlier slots, the code is nonzero.
- R4: When several earlier producers write the same register, the code names the nearest one, which is the smallest k.
- R5: Operands of slot 0, and operands of any slot whose `slot_valid` bit is 0, always get code 0.
- R6: A slot with index below `start_ofs` is never a producer, so no code points at it.
- R7: A slot with `has_dst`=0, with destination register 0, or with `slot_valid`=0 is never a producer.
- R8: Source operand j (0 or 1) of slot i uses bits [(2·i+j)·CW +: CW] of `dep_codes`, where CW = log2(N). Source register j of slot i is read from `src_regs` bits [(2·i+j)·REG_W +: REG_W], and the destination of slot i from `dst_regs` bits [i·REG_W +: REG_W].
- R9: While `in_valid` is 0, `dep_codes` keeps its previous value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is presented this cycle |
| start_ofs | input | CW | First slot at which the block is entered |
| slot_valid | input | N | Per-slot valid bit |
| has_dst | input | N | Per-slot flag that the slot writes a register |
| dst_regs | input | N·REG_W | Destination register of each slot |
| src_regs | input | 2·N·REG_W | Two source registers per slot |
| out_valid | output | 1 | `dep_codes` holds a freshly computed block |
| dep_codes | output | 2·N·CW | Dependency code per source operand |

## Verification
Two things decide a single code in the same cycle, and they can conflict: the choice of the nearest producer among several writers, and the removal of producers by the start offset or the zero-register rule. The bench provokes this with blocks in which every slot writes the same register, then moves the start offset past the nearest writer. This shows that the code is then 0 and does not fall back to a writer that is farther away and also excluded. Random blocks draw registers from a range of four values, so that several writers and excluded writers occur often. Each output is compared with a bench model that searches backward from each consumer and stops at the first producer it accepts.

// File: rtl/ibdep_pkg.sv
package ibdep_pkg;
    localparam int SRCS_PER_SLOT = 2;
    localparam int ZERO_REG      = 0;
endpackage

// File: rtl/ibdep_producer_filter.sv
module ibdep_producer_filter #(
    parameter int N     = 4,
    parameter int REG_W = 5,
    localparam int CW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]       slot_valid,
    input  logic [N-1:0]       has_dst,
    input  logic [N*REG_W-1:0] dst_regs,
    input  logic [CW-1:0]      start_ofs,
    output logic [N-1:0]       is_prod
);
    import ibdep_pkg::*;

    for (genvar s = 0; s < N; s++) begin : g_slot
        logic writes_real;
        logic in_window;
        assign writes_real = has_dst[s] && (dst_regs[s*REG_W +: REG_W] != REG_W'(ZERO_REG));
        assign in_window   = (s >= int'(start_ofs));
        assign is_prod[s]  = slot_valid[s] && writes_real && in_window;
    end
endmodule

// File: rtl/ibdep_finder.sv
module ibdep_finder #(
    parameter int N     = 4,
    parameter int REG_W = 5,
    parameter int SLOT  = 0,
    localparam int CW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cons_valid,
    input  logic [N-1:0]       is_prod,
    input  logic [N*REG_W-1:0] dst_regs,
    input  logic [REG_W-1:0]   src_reg,
    output logic [CW-1:0]      code
);
    always_comb begin
        code = '0;
        if (cons_valid) begin
            for (int d = SLOT; d >= 1; d--) begin
                if (is_prod[SLOT-d] && (dst_regs[(SLOT-d)*REG_W +: REG_W] == src_reg))
                    code = CW'(d);
            end
        end
    end

    // R3: a nonzero code must name an accepted producer writing this source
    assert_code_names_producer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code != '0) |-> ((int'(code) <= SLOT) && is_prod[SLOT - int'(code)] &&
                          (dst_regs[(SLOT - int'(code))*REG_W +: REG_W] == src_reg)));
endmodule

// File: rtl/intrablock_predecoder.sv
module intrablock_predecoder #(
    parameter int N     = 4,
    parameter int REG_W = 5,
    localparam int CW   = (N > 1) ? $clog2(N) : 1,
    localparam int NOPS = 2 * N
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CW-1:0]        start_ofs,
    input  logic [N-1:0]         slot_valid,
    input  logic [N-1:0]         has_dst,
    input  logic [N*REG_W-1:0]   dst_regs,
    input  logic [NOPS*REG_W-1:0] src_regs,
    output logic                 out_valid,
    output logic [NOPS*CW-1:0]   dep_codes
);
    import ibdep_pkg::*;

    logic [N-1:0]       is_prod;
    logic [NOPS*CW-1:0] next_codes;

    ibdep_producer_filter #(.N(N), .REG_W(REG_W)) u_filter (
        .slot_valid (slot_valid),
        .has_dst    (has_dst),
        .dst_regs   (dst_regs),
        .start_ofs  (start_ofs),
        .is_prod    (is_prod)
    );

    for (genvar i = 0; i < N; i++) begin : g_cons
        for (genvar j = 0; j < SRCS_PER_SLOT; j++) begin : g_src
            localparam int OP = SRCS_PER_SLOT*i + j;
            ibdep_finder #(.N(N), .REG_W(REG_W), .SLOT(i)) u_find (
                .clk        (clk),
                .rst_n      (rst_n),
                .cons_valid (slot_valid[i]),
                .is_prod    (is_prod),
                .dst_regs   (dst_regs),
                .src_reg    (src_regs[OP*REG_W +: REG_W]),
                .code       (next_codes[OP*CW +: CW])
            );

            // R6: no code may point at a slot before the start offset
            assert_ofs_respected_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (next_codes[OP*CW +: CW] != '0) |->
                    ((i - int'(next_codes[OP*CW +: CW])) >= int'(start_ofs)));
        end

        // R5: an invalid consumer slot leaves zero codes in the output
        assert_invalid_slot_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !slot_valid[i]) |=> (dep_codes[SRCS_PER_SLOT*i*CW +: SRCS_PER_SLOT*CW] == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dep_codes <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                dep_codes <= next_codes;
        end
    end

    // R2: the valid flag trails the input valid by one cycle
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: codes hold while no block is presented
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dep_codes));
endmodule

// File: tb/intrablock_predecoder_bench.sv
module intrablock_predecoder_bench;
    localparam int N     = 4;
    localparam int REG_W = 5;
    localparam int CW    = 2;
    localparam int NOPS  = 2 * N;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [CW-1:0]         start_ofs = '0;
    logic [N-1:0]          slot_valid = '0;
    logic [N-1:0]          has_dst = '0;
    logic [N*REG_W-1:0]    dst_regs = '0;
    logic [NOPS*REG_W-1:0] src_regs = '0;
    logic                  out_valid;
    logic [NOPS*CW-1:0]    dep_codes;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    intrablock_predecoder #(.N(N), .REG_W(REG_W)) u_intrablock_predecoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .start_ofs(start_ofs),
        .slot_valid(slot_valid), .has_dst(has_dst), .dst_regs(dst_regs),
        .src_regs(src_regs), .out_valid(out_valid), .dep_codes(dep_codes)
    );

    // Backward search from each consumer, stopping at the first accepted producer
    function automatic logic [NOPS*CW-1:0] model_codes();
        logic [NOPS*CW-1:0] res = '0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < 2; j++) begin
                logic [REG_W-1:0] s = src_regs[(2*i+j)*REG_W +: REG_W];
                if (slot_valid[i]) begin
                    for (int d = 1; d <= i; d++) begin
                        int p = i - d;
                        if (p >= int'(start_ofs) && slot_valid[p] && has_dst[p] &&
                            dst_regs[p*REG_W +: REG_W] != 0 &&
                            dst_regs[p*REG_W +: REG_W] == s) begin
                            res[(2*i+j)*CW +: CW] = CW'(d);
                            break;
                        end
                    end
                end
            end
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input bit v, input bit hd, input int d, input int s0, input int s1);
        slot_valid[i] = v;
        has_dst[i] = hd;
        dst_regs[i*REG_W +: REG_W] = REG_W'(d);
        src_regs[(2*i)*REG_W +: REG_W] = REG_W'(s0);
        src_regs[(2*i+1)*REG_W +: REG_W] = REG_W'(s1);
    endtask

    // Inputs are applied at a falling edge; the result is sampled one cycle later
    task automatic run_block(input string tag, output logic [NOPS*CW-1:0] exp);
        exp = model_codes();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R2 valid"}, 64'(out_valid), 64'd1);
        check(tag, 64'(dep_codes), 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [NOPS*CW-1:0] exp;
        logic [NOPS*CW-1:0] held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", 64'(out_valid), 64'd0);
        check("R1 codes in reset", 64'(dep_codes), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        check("R1 codes after reset", 64'(dep_codes), 64'd0);

        // R8: slot 3 operand 1 depends on slot 0, so bits [15:14] hold 3
        start_ofs = 0;
        set_slot(0, 1, 1, 9, 1, 2);
        set_slot(1, 1, 1, 10, 3, 4);
        set_slot(2, 1, 1, 11, 5, 6);
        set_slot(3, 1, 1, 12, 7, 9);
        run_block("R8 far producer", exp);
        check("R8 field slot3 op1", 64'(dep_codes[15:14]), 64'd3);
        check("R3 field value", 64'(dep_codes[15:14]), 64'(exp[15:14]));

        // R6: offset 1 removes slot 0 as producer
        start_ofs = 1;
        run_block("R6 offset ignores slot0", exp);
        check("R6 field slot3 op1 zero", 64'(dep_codes[15:14]), 64'd0);

        // R4: all slots write r3; nearest writer is named
        start_ofs = 0;
        set_slot(0, 1, 1, 3, 3, 3);
        set_slot(1, 1, 1, 3, 3, 7);
        set_slot(2, 1, 1, 3, 3, 3);
        set_slot(3, 1, 1, 3, 3, 3);
        run_block("R4 nearest writer", exp);
        check("R4 slot3 op0 is 1", 64'(dep_codes[13:12]), 64'd1);
        check("R5 slot0 zero", 64'(dep_codes[3:0]), 64'd0);

        // R4 with R6: offset 3 drops every earlier writer, no fallback
        start_ofs = 3;
        run_block("R4 R6 offset past all writers", exp);
        check("R6 slot3 op0 zero", 64'(dep_codes[13:12]), 64'd0);

        // R7: no-destination and zero-register writers are ignored
        start_ofs = 0;
        set_slot(0, 1, 0, 9, 1, 1);
        set_slot(1, 1, 1, 0, 9, 0);
        set_slot(2, 1, 1, 5, 0, 9);
        set_slot(3, 0, 1, 6, 5, 5);
        run_block("R7 non producers", exp);
        check("R7 slot2 op1 zero", 64'(dep_codes[11:10]), 64'd0);
        check("R5 invalid slot3 zero", 64'(dep_codes[15:12]), 64'd0);

        // R7: invalid slot is not a producer
        set_slot(0, 0, 1, 8, 1, 1);
        set_slot(1, 1, 1, 2, 8, 8);
        set_slot(3, 1, 1, 6, 2, 8);
        run_block("R7 invalid producer", exp);
        check("R7 slot1 op0 zero", 64'(dep_codes[5:4]), 64'd0);
        check("R3 slot3 op0 is 2", 64'(dep_codes[13:12]), 64'd2);

        // R9: hold while idle under changing inputs
        held = dep_codes;
        set_slot(0, 1, 1, 4, 0, 0);
        set_slot(1, 1, 1, 1, 4, 4);
        set_slot(2, 1, 1, 1, 1, 4);
        @(negedge clk);
        @(negedge clk);
        check("R9 codes held", 64'(dep_codes), 64'(held));
        check("R2 idle valid", 64'(out_valid), 64'd0);

        // R3: random blocks with a narrow register range
        for (int n = 0; n < 400; n++) begin
            start_ofs = CW'($urandom_range(0, N-1));
            for (int i = 0; i < N; i++)
                set_slot(i, ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) != 0),
                         $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3));
            run_block("R3 random", exp);
            if (n % 5 == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule